// File: doc/BRIEF.md
# Narrow Pulse Stretch Synchronizer

This block moves an event marked by a short asynchronous pulse into a destination clock domain. The pulse may be much narrower than one destination clock period, and it may also be several periods wide. Each captured event comes out as a pulse exactly one destination clock cycle wide. Sampling the input with the destination clock would miss a narrow pulse. Instead, the rising edge of the input clocks a capture flop whose data input is tied to logic 1, so the event is held as a level until the destination domain has seen it.

The held level passes through two flops clocked by the destination clock. The first of these may go metastable and is given a full cycle to settle. The second turns the level into a single-cycle output. While that output is high, the capture flop is cleared asynchronously, which re-arms the block for the next event. The one-cycle output stage has two forms, chosen by a parameter. The first form uses an AND gate to combine the synchronized level with the inverted output. The second form gives the output flop a synchronous reset taken from its own state, which keeps the gate out of the settling path of the first flop. Both forms behave the same at the ports.

The block is meant for strobes from an external device whose timing is not tied to the local clock. Events must be spaced far enough apart for the clear to complete; events closer together are merged.

Top module: `pulse_catch_sync`

## Requirements
- R1: While `rst_n` is low, `sync_pulse` is 0 and input edges are ignored. After release with no input edge, `sync_pulse` stays 0.
- R2: A single input pulse of any width below one destination period produces exactly one `sync_pulse` pulse of exactly one `dst_clk` cycle.
- R3: `sync_pulse` rises no earlier than the second and no later than the third rising `dst_clk` edge after the input rising edge. With no metastability, it rises at the second edge.
- R4: An input pulse held high for several destination cycles produces exactly one output pulse, because only its rising edge is captured.
- R5: Input rising edges spaced at least 4 `dst_clk` cycles apart each produce exactly one output pulse.
- R6: A second input rising edge that arrives before the first has been delivered is merged with the first. Two edges within the same destination cycle give one output pulse.
- R7: `sync_pulse` is never high on two consecutive `dst_clk` cycles.
- R8: Both forms of the output stage (parameter `SYNC_CLR_FORM` = 0 or 1) produce identical `sync_pulse` waveforms for the same inputs.
- R9: Asserting `rst_n` low after an input edge but before its output pulse cancels that event. No output pulse appears after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dst_clk | input | 1 | Destination domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for all flops |
| async_pulse | input | 1 | Asynchronous event strobe; its rising edge is captured |
| sync_pulse | output | 1 | One-cycle event pulse in the `dst_clk` domain |

## Verification
A capture flop that never clears shows up at the ports as no further output pulses after the first event. A clear that releases too early shows up as a second output pulse one or two cycles after the first. Either fault is visible within three destination cycles of the next input edge. A wrong edge detector shows up in the very cycle after the output rises, as a pulse two cycles wide or as one that repeats. A wrong synchronizer depth moves the rising edge off the second destination edge. The bench measures that edge directly and compares every cycle with a behavioural event model.

// File: rtl/pulse_catch_sync.sv
`timescale 1ns/1ps
module pulse_catch_sync #(
  parameter bit SYNC_CLR_FORM = 1'b0
) (
  input  logic dst_clk,
  input  logic rst_n,
  input  logic async_pulse,
  output logic sync_pulse
);

  logic cap_q;
  logic meta_q;
  logic pulse_q;
  logic cap_clr;

  assign cap_clr = ~rst_n | pulse_q;

  always_ff @(posedge async_pulse or posedge cap_clr) begin
    if (cap_clr) cap_q <= 1'b0;
    else         cap_q <= 1'b1;
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) meta_q <= 1'b0;
    else        meta_q <= cap_q;
  end

  generate
    if (SYNC_CLR_FORM) begin : g_self_clear
      always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n)       pulse_q <= 1'b0;
        else if (pulse_q) pulse_q <= 1'b0;
        else              pulse_q <= meta_q;
      end
    end else begin : g_gated
      logic edge_d;
      assign edge_d = meta_q & ~pulse_q;
      always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= edge_d;
      end
    end
  endgenerate

  assign sync_pulse = pulse_q;

endmodule

// File: rtl/pulse_catch_sync_chk.sv
`timescale 1ns/1ps
module pulse_catch_sync_chk (
  input logic clk,
  input logic rst_n,
  input logic cap_q,
  input logic meta_q,
  input logic pulse_o
);

  // R7
  no_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  // R2
  cap_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> !cap_q);

  // R3
  quiet_without_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meta_q |=> !pulse_o);

  // R1
  post_reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pulse_o);

endmodule

bind pulse_catch_sync pulse_catch_sync_chk u_chk (
  .clk     (dst_clk),
  .rst_n   (rst_n),
  .cap_q   (cap_q),
  .meta_q  (meta_q),
  .pulse_o (sync_pulse)
);

// File: tb/pulse_catch_sync_bench.sv
`timescale 1ns/1ps
module pulse_catch_sync_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic out_a;
  logic out_b;

  int checks = 0;
  int errors = 0;
  int pulse_cnt = 0;
  int stage = 0;
  logic pin_last = 1'b0;
  logic prev_out = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  pulse_catch_sync #(.SYNC_CLR_FORM(1'b0)) u_pulse_catch_sync (
    .dst_clk(clk), .rst_n(rst_n), .async_pulse(pin), .sync_pulse(out_a));

  pulse_catch_sync #(.SYNC_CLR_FORM(1'b1)) u_pulse_catch_sync_alt (
    .dst_clk(clk), .rst_n(rst_n), .async_pulse(pin), .sync_pulse(out_b));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // event model: 0 idle, 1 held, 2 synced, 3 delivering (clear active)
  always @(posedge clk or posedge pin or negedge pin or negedge rst_n) begin
    if (!rst_n) begin
      stage = 0;
    end else if (pin && !pin_last) begin
      if (stage == 0) stage = 1;
    end else if (pin == pin_last) begin
      if (stage == 1)      stage = 2;
      else if (stage == 2) stage = 3;
      else if (stage == 3) stage = 0;
    end
    pin_last = pin;
  end

  always @(negedge clk) begin
    chk(out_a == (stage == 3), cur_req, "model compare", int'(out_a), int'(stage == 3));
    chk(out_a == out_b, "R8", "forms differ", int'(out_b), int'(out_a));
    if (prev_out && out_a) chk(1'b0, "R7", "two-cycle pulse", 1, 0);
    if (out_a && !prev_out) pulse_cnt++;
    prev_out = out_a;
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic fire(input realtime w);
    pin = 1'b1;
    #w;
    pin = 1'b0;
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    int n;
    // R1: reset holds output low, edges during reset ignored
    cycles(1);
    fire(0.4);
    cycles(3);
    chk(out_a == 1'b0, "R1", "output in reset", int'(out_a), 0);
    rst_n = 1'b1;
    base = pulse_cnt;
    cycles(6);
    chk(pulse_cnt - base == 0, "R1", "pulses after release", pulse_cnt - base, 0);

    // R2: single narrow pulse
    cur_req = "R2";
    base = pulse_cnt;
    fire(0.3);
    cycles(8);
    chk(pulse_cnt - base == 1, "R2", "narrow pulse count", pulse_cnt - base, 1);

    // R3: latency in destination edges
    cur_req = "R3";
    base = pulse_cnt;
    fire(0.5);
    n = 0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk);
      n++;
      #1;
      if (out_a) break;
    end
    chk(n == 2, "R3", "edges to output", n, 2);
    cycles(6);
    chk(pulse_cnt - base == 1, "R3", "latency pulse count", pulse_cnt - base, 1);

    // R4: wide input pulse
    cur_req = "R4";
    base = pulse_cnt;
    fire(20.0);
    cycles(8);
    chk(pulse_cnt - base == 1, "R4", "wide pulse count", pulse_cnt - base, 1);

    // R6: two edges in one destination cycle merge
    cur_req = "R6";
    base = pulse_cnt;
    fire(0.4);
    #1.5;
    fire(0.4);
    cycles(8);
    chk(pulse_cnt - base == 1, "R6", "merged pulse count", pulse_cnt - base, 1);

    // R5: train spaced 4 cycles
    cur_req = "R5";
    base = pulse_cnt;
    for (int k = 0; k < 5; k++) begin
      fire(0.6);
      cycles(4);
    end
    cycles(6);
    chk(pulse_cnt - base == 5, "R5", "spaced train count", pulse_cnt - base, 5);

    // R5: train spaced 5 cycles with varying widths
    base = pulse_cnt;
    for (int k = 0; k < 4; k++) begin
      fire(0.2 + k * 1.5);
      cycles(5);
    end
    cycles(6);
    chk(pulse_cnt - base == 4, "R5", "second train count", pulse_cnt - base, 4);

    // R9: reset cancels a captured event
    cur_req = "R9";
    base = pulse_cnt;
    fire(0.4);
    #0.5;
    rst_n = 1'b0;
    cycles(2);
    chk(out_a == 1'b0, "R9", "output during reset", int'(out_a), 0);
    rst_n = 1'b1;
    cycles(8);
    chk(pulse_cnt - base == 0, "R9", "cancelled pulse count", pulse_cnt - base, 0);

    // R2: block re-armed after reset
    cur_req = "R2";
    base = pulse_cnt;
    fire(0.3);
    cycles(8);
    chk(pulse_cnt - base == 1, "R2", "pulse after reset", pulse_cnt - base, 1);

    finish_run();
  end

endmodule